// File: doc/BRIEF.md
# 8-bit ALU with decimal adjust

This block computes the result byte and the new status byte for one arithmetic, logic, compare, bit-test or shift instruction of an 8-bit accumulator machine. The caller has already fetched the operand. It presents a 4-bit operation code, the accumulator, an index register, the operand and the current status byte. The block returns the result and the updated status on combinational outputs within the same cycle. Writing the result back to a register or to memory stays with the caller.

The addition path works in binary or in packed BCD, according to the decimal flag in the incoming status. Subtraction adds the inverted operand with a forced carry of one, then takes one away afterwards when the incoming carry was clear. A registered copy of the result and status is also provided. It is loaded on an input strobe and appears one cycle later, together with an output-valid flag.

Top module: `alu8_unit`

## Requirements
- R1: Status bits are carry=bit0, zero=bit1, interrupt-mask=bit2, decimal=bit3, break=bit4, spare=bit5, overflow=bit6, negative=bit7. Operation code 0 (add) forms the 9-bit value acc+operand+carry. With the decimal bit clear, the result is its low byte, carry is set when the value exceeds 0xFF, and overflow is set when acc and operand have the same bit 7 and the result's bit 7 differs from acc's.
- R2: With the decimal bit set, add takes the low byte of the 9-bit value. It adds 0x06 when that byte's low nibble is above 9, and adds 0x60 when the 9-bit value is above 0x99. Carry equals (9-bit value > 0x99) and overflow is cleared.
- R3: Operation code 1 (subtract) runs the add of R1/R2 on the inverted operand with a carry-in of one. When the incoming carry was 0, one is then taken from the result. Carry and overflow come from the add step. Zero and negative come from the final result.
- R4: Operation codes 2, 3 and 4 give acc OR, AND and XOR operand.
- R5: Operation code 5 compares acc and code 6 compares the index register against the operand. Carry = (register >= operand), and zero/negative come from the 8-bit difference. The result output equals the compared register, and overflow is unchanged.
- R6: Operation code 7 (bit test) sets zero when acc AND operand is 0, negative from operand bit 7 and overflow from operand bit 6. The result output equals acc and carry is unchanged.
- R7: Operation codes 8 to 11 shift the operand: 8 shifts left, 9 shifts right, 10 rotates left through carry, 11 rotates right through carry. The bit shifted out goes into carry. A rotate inserts the old carry at bit 0 (left) or bit 7 (right).
- R8: For codes 0-4 and 8-11, zero is set exactly when the result is 0 and negative equals result bit 7. No operation changes status bits 2 to 5.
- R9: Operation codes 12 to 15 return the operand as the result with the status unchanged.
- R10: When in_vld is high at a clock edge, res_q and stat_q take the combinational result and status and out_vld goes high for the next cycle. When in_vld is low they hold and out_vld is low.
- R11: While rst_n is low at a clock edge, res_q, stat_q and out_vld are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Load strobe for the registered outputs |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| idx_i | input | 8 | Index register value, used by the index compare |
| opnd_i | input | 8 | Operand value |
| stat_i | input | 8 | Current status byte |
| res_c | output | 8 | Combinational result |
| stat_c | output | 8 | Combinational new status |
| res_q | output | 8 | Registered result |
| stat_q | output | 8 | Registered status |
| out_vld | output | 1 | Registered outputs were loaded on the last edge |

## Verification
A fault in the add path, such as a lost correction nibble, a wrong carry rule or a misplaced borrow, shows on res_c and stat_c in the same cycle the inputs are applied. The same fault reaches res_q and stat_q one edge later. A wrong latch enable or valid flag appears only at the registered outputs, on the first edge after the strobe changes. Decimal corner values, sign-crossing sums and carry-in variations are therefore checked directly at the outputs and compared against a bench model written from the requirements.

// File: rtl/alu8_pkg.sv
// Package: operation codes and status bit positions shared by the ALU and its bench.
package alu8_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_OR   = 4'd2,
        OP_AND  = 4'd3,
        OP_XOR  = 4'd4,
        OP_CMPA = 4'd5,
        OP_CMPX = 4'd6,
        OP_BIT  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_ROTL = 4'd10,
        OP_ROTR = 4'd11
    } alu_op_e;

    localparam int ST_C = 0;
    localparam int ST_Z = 1;
    localparam int ST_I = 2;
    localparam int ST_D = 3;
    localparam int ST_B = 4;
    localparam int ST_U = 5;
    localparam int ST_V = 6;
    localparam int ST_N = 7;
endpackage

// File: rtl/alu8_adder.sv
// Adder with optional packed-BCD correction on one byte.
// Assumes DW >= 8; the decimal correction touches the low byte only.
module alu8_adder #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          dec_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          ovf_o
);
    localparam logic [DW:0]   DEC_LIM = (DW+1)'(9'h099);
    localparam logic [DW-1:0] LO_FIX  = DW'(8'h06);
    localparam logic [DW-1:0] HI_FIX  = DW'(8'h60);

    logic [DW:0]   raw;
    logic [DW-1:0] adj;
    logic          dec_carry;

    // Raw binary sum and the decimal correction amount.
    always_comb begin
        raw       = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i};
        dec_carry = (raw > DEC_LIM);
        adj       = '0;
        if (raw[3:0] > 4'd9) adj = adj + LO_FIX;
        if (dec_carry)       adj = adj + HI_FIX;
    end

    // Select binary or corrected outputs.
    always_comb begin
        if (dec_i) begin
            sum_o  = raw[DW-1:0] + adj;
            cout_o = dec_carry;
            ovf_o  = 1'b0;
        end else begin
            sum_o  = raw[DW-1:0];
            cout_o = raw[DW];
            ovf_o  = (a_i[DW-1] == b_i[DW-1]) && (raw[DW-1] != a_i[DW-1]);
        end
    end
endmodule

// File: rtl/alu8_shift.sv
// One-position shifter/rotator; kind_i: 0 left, 1 right, 2 rotate left, 3 rotate right.
// Assumes the caller feeds the current carry on cin_i.
module alu8_shift #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] val_i,
    input  logic [1:0]    kind_i,
    input  logic          cin_i,
    output logic [DW-1:0] val_o,
    output logic          cout_o
);
    logic fill;

    // Bit entering the vacated end: old carry for rotates, zero for shifts.
    always_comb fill = kind_i[1] & cin_i;

    // Direction select.
    always_comb begin
        if (kind_i[0]) begin
            val_o  = {fill, val_i[DW-1:1]};
            cout_o = val_i[0];
        end else begin
            val_o  = {val_i[DW-2:0], fill};
            cout_o = val_i[DW-1];
        end
    end
endmodule

// File: rtl/alu8_unit.sv
// 8-bit ALU: add/subtract (binary or BCD), logic, compare, bit test and shifts,
// with combinational outputs and a strobe-loaded registered copy.
// Assumes operands are already fetched; status layout from alu8_pkg.
module alu8_unit
    import alu8_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] idx_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [DW-1:0] stat_i,
    output logic [DW-1:0] res_c,
    output logic [DW-1:0] stat_c,
    output logic [DW-1:0] res_q,
    output logic [DW-1:0] stat_q,
    output logic          out_vld
);
    logic          is_sub;
    logic [DW-1:0] add_b;
    logic          add_cin;
    logic [DW-1:0] add_sum;
    logic          add_cout, add_ovf;
    logic [DW-1:0] cmp_reg, cmp_diff;
    logic          cmp_ge, cmp_ovf_unused;
    logic [DW-1:0] sh_val;
    logic          sh_cout;
    logic [DW-1:0] res_n;
    logic [DW-1:0] st_n;
    logic          zn_upd;

    // Adder operand steering: subtract inverts operand and forces carry-in.
    always_comb begin
        is_sub  = (op_i == OP_SUB);
        add_b   = is_sub ? ~opnd_i : opnd_i;
        add_cin = is_sub ? 1'b1 : stat_i[ST_C];
    end

    alu8_adder #(.DW(DW)) add_i (
        .a_i   (acc_i),
        .b_i   (add_b),
        .cin_i (add_cin),
        .dec_i (stat_i[ST_D]),
        .sum_o (add_sum),
        .cout_o(add_cout),
        .ovf_o (add_ovf)
    );

    // Compare register select.
    always_comb cmp_reg = (op_i == OP_CMPX) ? idx_i : acc_i;

    alu8_adder #(.DW(DW)) cmp_i (
        .a_i   (cmp_reg),
        .b_i   (~opnd_i),
        .cin_i (1'b1),
        .dec_i (1'b0),
        .sum_o (cmp_diff),
        .cout_o(cmp_ge),
        .ovf_o (cmp_ovf_unused)
    );

    alu8_shift #(.DW(DW)) sh_i (
        .val_i (opnd_i),
        .kind_i(op_i[1:0]),
        .cin_i (stat_i[ST_C]),
        .val_o (sh_val),
        .cout_o(sh_cout)
    );

    // Result and flag selection per operation.
    always_comb begin
        res_n  = opnd_i;
        st_n   = stat_i;
        zn_upd = 1'b1;
        case (op_i)
            OP_ADD: begin
                res_n       = add_sum;
                st_n[ST_C]  = add_cout;
                st_n[ST_V]  = add_ovf;
            end
            OP_SUB: begin
                res_n       = add_sum - DW'(!stat_i[ST_C]);
                st_n[ST_C]  = add_cout;
                st_n[ST_V]  = add_ovf;
            end
            OP_OR:  res_n = acc_i | opnd_i;
            OP_AND: res_n = acc_i & opnd_i;
            OP_XOR: res_n = acc_i ^ opnd_i;
            OP_CMPA, OP_CMPX: begin
                res_n       = cmp_reg;
                zn_upd      = 1'b0;
                st_n[ST_C]  = cmp_ge;
                st_n[ST_Z]  = (cmp_diff == '0);
                st_n[ST_N]  = cmp_diff[DW-1];
            end
            OP_BIT: begin
                res_n       = acc_i;
                zn_upd      = 1'b0;
                st_n[ST_Z]  = ((acc_i & opnd_i) == '0);
                st_n[ST_N]  = opnd_i[DW-1];
                st_n[ST_V]  = opnd_i[DW-2];
            end
            OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
                res_n       = sh_val;
                st_n[ST_C]  = sh_cout;
            end
            default: zn_upd = 1'b0;
        endcase
        if (zn_upd) begin
            st_n[ST_Z] = (res_n == '0);
            st_n[ST_N] = res_n[DW-1];
        end
    end

    always_comb begin
        res_c  = res_n;
        stat_c = st_n;
    end

    // Registered copy loaded on the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            stat_q  <= '0;
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                res_q  <= res_c;
                stat_q <= stat_c;
            end
        end
    end
endmodule

// Checker: port-level properties of the ALU.
module alu8_unit_chk
    import alu8_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vld,
    input logic [3:0]    op_i,
    input logic [DW-1:0] acc_i,
    input logic [DW-1:0] idx_i,
    input logic [DW-1:0] opnd_i,
    input logic [DW-1:0] stat_i,
    input logic [DW-1:0] res_c,
    input logic [DW-1:0] stat_c,
    input logic [DW-1:0] res_q,
    input logic [DW-1:0] stat_q,
    input logic          out_vld
);
    // R2
    dec_add_vclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ADD && stat_i[ST_D]) |-> !stat_c[ST_V]);

    // R8
    ctl_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_c[ST_U:ST_I] == stat_i[ST_U:ST_I]);

    // R8
    zn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i <= OP_XOR || (op_i >= OP_SHL && op_i <= OP_ROTR)) |->
        (stat_c[ST_Z] == (res_c == '0) && stat_c[ST_N] == res_c[DW-1]));

    // R5
    cmp_keep_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMPX) |-> (res_c == idx_i && stat_c[ST_V] == stat_i[ST_V]));

    // R9
    spare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd12) |-> (res_c == opnd_i && stat_c == stat_i));

    // R10
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_vld && res_q == $past(res_c) && stat_q == $past(stat_c)));

    // R10
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(res_q) && $stable(stat_q)));
endmodule

bind alu8_unit alu8_unit_chk #(.DW(DW)) chk_i (.*);

// File: tb/alu8_unit_tb_top.sv
// Directed bench for alu8_unit with a requirement-derived reference model.
module alu8_unit_tb_top;
    import alu8_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'h00, idx_i = 8'h00, opnd_i = 8'h00, stat_i = 8'h00;
    logic [7:0] res_c, stat_c, res_q, stat_q;
    logic       out_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_i(op_i),
        .acc_i(acc_i), .idx_i(idx_i), .opnd_i(opnd_i), .stat_i(stat_i),
        .res_c(res_c), .stat_c(stat_c), .res_q(res_q), .stat_q(stat_q),
        .out_vld(out_vld)
    );

    // Reference model: returns {result, status}.
    function automatic logic [15:0] ref_model(logic [3:0] op, logic [7:0] a, logic [7:0] x,
                                              logic [7:0] m, logic [7:0] s);
        logic [7:0] r, ns, b;
        logic [8:0] t;
        bit zn;
        r = m; ns = s; zn = 1'b0;
        if (op <= 4'd1) begin
            b = (op == 4'd1) ? ~m : m;
            t = {1'b0, a} + {1'b0, b} + ((op == 4'd1) ? 9'd1 : {8'd0, s[0]});
            r = t[7:0];
            if (s[3]) begin
                if (t[3:0] > 4'd9) r = r + 8'h06;
                if (t > 9'h099)    r = r + 8'h60;
                ns[0] = (t > 9'h099);
                ns[6] = 1'b0;
            end else begin
                ns[0] = t[8];
                ns[6] = (a[7] == b[7]) && (r[7] != a[7]);
            end
            if (op == 4'd1 && !s[0]) r = r - 8'd1;
            zn = 1'b1;
        end else if (op == 4'd2) begin r = a | m; zn = 1'b1; end
        else if (op == 4'd3) begin r = a & m; zn = 1'b1; end
        else if (op == 4'd4) begin r = a ^ m; zn = 1'b1; end
        else if (op == 4'd5 || op == 4'd6) begin
            r = (op == 4'd5) ? a : x;
            ns[0] = (r >= m);
            ns[1] = ((r - m) == 8'h00);
            ns[7] = (r - m) >> 7 != 8'h00;
        end else if (op == 4'd7) begin
            r = a;
            ns[1] = ((a & m) == 8'h00);
            ns[7] = m[7];
            ns[6] = m[6];
        end else if (op == 4'd8)  begin r = m << 1; ns[0] = m[7]; zn = 1'b1; end
        else if (op == 4'd9)  begin r = m >> 1; ns[0] = m[0]; zn = 1'b1; end
        else if (op == 4'd10) begin r = {m[6:0], s[0]}; ns[0] = m[7]; zn = 1'b1; end
        else if (op == 4'd11) begin r = {s[0], m[7:1]}; ns[0] = m[0]; zn = 1'b1; end
        if (zn) begin
            ns[1] = (r == 8'h00);
            ns[7] = r[7];
        end
        return {r, ns};
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Apply inputs at the falling edge and let combinational outputs settle.
    task automatic drive(logic [3:0] op, logic [7:0] a, logic [7:0] x, logic [7:0] m,
                         logic [7:0] s);
        @(negedge clk);
        op_i = op; acc_i = a; idx_i = x; opnd_i = m; stat_i = s;
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R11 reset", {res_q, stat_q}, 16'h0000);
        check("R11 reset vld", {15'd0, out_vld}, 16'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_add_bin();
        drive(4'd0, 8'h50, 8'h00, 8'h50, 8'h24);
        check("R1 add signed overflow", {res_c, stat_c}, {8'hA0, 8'hE4});
        drive(4'd0, 8'hFF, 8'h00, 8'h01, 8'h20);
        check("R1 add carry out", {res_c, stat_c}, {8'h00, 8'h23});
        drive(4'd0, 8'h10, 8'h00, 8'h20, 8'h21);
        check("R1 add carry in", {res_c, stat_c}, {8'h31, 8'h20});
    endtask

    task automatic t_add_dec();
        drive(4'd0, 8'h45, 8'h00, 8'h38, 8'h68);
        check("R2 decimal nibble fix", {res_c, stat_c}, {8'h83, 8'hA8});
        drive(4'd0, 8'h99, 8'h00, 8'h01, 8'h28);
        check("R2 decimal wrap", {res_c, stat_c}, {8'h00, 8'h2B});
    endtask

    task automatic t_sub();
        drive(4'd1, 8'h50, 8'h00, 8'h30, 8'h21);
        check("R3 sub no borrow", {res_c, stat_c}, {8'h20, 8'h21});
        drive(4'd1, 8'h10, 8'h00, 8'h10, 8'h20);
        check("R3 sub with borrow", {res_c, stat_c}, {8'hFF, 8'hA1});
    endtask

    task automatic t_logic();
        drive(4'd2, 8'h0F, 8'h00, 8'h80, 8'h20);
        check("R4 or", {res_c, stat_c}, {8'h8F, 8'hA0});
        drive(4'd3, 8'h0F, 8'h00, 8'hF0, 8'h20);
        check("R4 and zero", {res_c, stat_c}, {8'h00, 8'h22});
        drive(4'd4, 8'hFF, 8'h00, 8'h0F, 8'h20);
        check("R4 xor", {res_c, stat_c}, {8'hF0, 8'hA0});
    endtask

    task automatic t_cmp();
        drive(4'd5, 8'h40, 8'h00, 8'h40, 8'h60);
        check("R5 cmp acc equal", {res_c, stat_c}, {8'h40, 8'h63});
        drive(4'd6, 8'h99, 8'h10, 8'h20, 8'h21);
        check("R5 cmp index below", {res_c, stat_c}, {8'h10, 8'hA0});
    endtask

    task automatic t_bit();
        drive(4'd7, 8'h0F, 8'h00, 8'hC0, 8'h21);
        check("R6 bit test", {res_c, stat_c}, {8'h0F, 8'hE3});
    endtask

    task automatic t_shift();
        drive(4'd8, 8'h00, 8'h00, 8'h81, 8'h20);
        check("R7 shift left", {res_c, stat_c}, {8'h02, 8'h21});
        drive(4'd9, 8'h00, 8'h00, 8'h01, 8'h20);
        check("R7 shift right", {res_c, stat_c}, {8'h00, 8'h23});
        drive(4'd10, 8'h00, 8'h00, 8'h80, 8'h20);
        check("R7 rotate left", {res_c, stat_c}, {8'h00, 8'h23});
        drive(4'd11, 8'h00, 8'h00, 8'h01, 8'h21);
        check("R7 rotate right", {res_c, stat_c}, {8'h80, 8'hA1});
    endtask

    task automatic t_pass();
        drive(4'd12, 8'h11, 8'h22, 8'h5A, 8'hC3);
        check("R9 unused code 12", {res_c, stat_c}, {8'h5A, 8'hC3});
        drive(4'd15, 8'hFF, 8'h00, 8'h00, 8'h3C);
        check("R9 unused code 15", {res_c, stat_c}, {8'h00, 8'h3C});
    endtask

    task automatic t_reg();
        drive(4'd0, 8'h12, 8'h00, 8'h34, 8'h20);
        in_vld = 1'b1;
        @(negedge clk);
        check("R10 load", {res_q, stat_q}, {8'h46, 8'h20});
        check("R10 valid high", {15'd0, out_vld}, 16'd1);
        in_vld = 1'b0; op_i = 4'd2; opnd_i = 8'hFF;
        @(negedge clk);
        check("R10 hold", {res_q, stat_q}, {8'h46, 8'h20});
        check("R10 valid low", {15'd0, out_vld}, 16'd0);
    endtask

    // Sweep of all codes and flag combinations against the model (R8 and others).
    task automatic t_sweep();
        logic [7:0] a = 8'h3B, m = 8'hC5, x = 8'h77;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] s;
            s = {i[7:6], 1'b1, i[4], i[3], i[2], i[1], i[0]};
            drive(i[3:0] ^ i[7:4], a, x, m, s);
            check("R8 sweep vs model", {res_c, stat_c}, ref_model(op_i, a, x, m, s));
            a = a * 8'd5 + 8'd17;
            m = m * 8'd13 + 8'd7;
            x = x + 8'd29;
        end
    endtask

    initial begin
        t_reset();
        t_add_bin();
        t_add_dec();
        t_sub();
        t_logic();
        t_cmp();
        t_bit();
        t_shift();
        t_pass();
        t_reg();
        t_sweep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule